// File: doc/BRIEF.md
# Three-Level Write Delay Code Encoder

This block turns a write-delay setting made of three nested counters into a legal register code. The fine level f counts whole turns of the coarse level t, and t counts whole turns of the phase p. A search engine steps the delay one unit at a time and may push any field past its range in either direction. The block carries and borrows between the levels, saturates the result when f leaves its four legal values, and flags the direction of that saturation. The wrap point of t depends on a clock-mode bit.

The block also returns the hardware fields that follow from the normalised code. In fast mode it replaces the phase with a fixed value near one coarse boundary. For every code it gives a 2-bit range class taken from per-mode coarse thresholds. A second request type takes two already-normalised codes, usually a lower and an upper edge. It returns their midpoint as a code through the same field logic. Every request is a single strobe and its result appears registered one cycle later.

Top module: `wdc_encoder`

## Requirements
- R1: The phase wraps at 8. A phase of 8 or more carries into t, and a negative phase borrows from t, so (f,t,p) = (0,0,8) gives (0,1,0) and (1,0,-1) in slow mode gives (0,10,7).
- R2: The coarse value wraps into f at 12 in fast mode (fast_mode=1) and at 11 in slow mode, in both directions. A valid result always has res_t below the bound of its mode.
- R3: A normalised f below 0 gives res_f=0, res_t=0, res_p=0 with res_under=1.
- R4: A normalised f of 4 or more gives res_f=3, res_t=bound-1, res_p=7 with res_over=1.
- R5: res_under and res_over are never high together. Both are low whenever the normalised f lies in 0..3.
- R6: In fast mode res_p is 4 when t=9 and p≥4, or when t=10 and p<4. Otherwise the normalised p passes through.
- R7: In slow mode res_p always equals the normalised phase, with no override.
- R8: res_d is 2'b11 when t ≤ low threshold, 2'b01 when t > high threshold, and 2'b00 otherwise. The thresholds are (1,6) in slow mode and (2,9) in fast mode. 2'b10 never appears.
- R9: With req_mid=1, each input code is linearised as v=((f·bound+t)·8+p). The result is the code for (va+vb)>>1, split as f=v/(bound·8), t=(v>>3) mod bound and p=v&7.
- R10: res_valid rises exactly one cycle after a cycle with req_valid=1 and is low otherwise. Synchronous reset clears res_valid and all result fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one result per strobe |
| req_mid | input | 1 | 0: normalise dly_*; 1: midpoint of lo_* and hi_* |
| fast_mode | input | 1 | Clock mode: 1 selects bound 12 and thresholds (2,9) |
| dly_f | input | IN_W | Signed fine level to normalise |
| dly_t | input | IN_W | Signed coarse level to normalise |
| dly_p | input | IN_W | Signed phase to normalise |
| lo_f | input | 2 | Fine level of first normalised code |
| lo_t | input | 4 | Coarse level of first normalised code |
| lo_p | input | 3 | Phase of first normalised code |
| hi_f | input | 2 | Fine level of second normalised code |
| hi_t | input | 4 | Coarse level of second normalised code |
| hi_p | input | 3 | Phase of second normalised code |
| res_valid | output | 1 | Result valid |
| res_f | output | 2 | Fine field |
| res_t | output | 4 | Coarse field |
| res_p | output | 3 | Phase field after fast-mode override |
| res_d | output | 2 | Range class field |
| res_under | output | 1 | Saturated at the low end |
| res_over | output | 1 | Saturated at the high end |

## Verification
The embedded properties watch every cycle for exclusive saturation flags and for the fixed saturated values at each end. They also check that the coarse field stays below the bound of the mode, that the range class never takes its unused code, that the fast-mode phase near t=9 never exceeds 4, and that results arrive at the one-cycle latency. Only the bench scenarios can show the arithmetic itself. That covers carries and borrows across both levels, the exact wrap point in each mode, where each threshold flips, the phase passing unchanged in slow mode, and the midpoint split. The bench compares each result against a step-by-step model run on directed boundary codes and on a long random mix of both request types.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int F_W = 2;
  localparam int T_W = 4;
  localparam int P_W = 3;

  typedef enum logic [1:0] {
    D_MID  = 2'b00,
    D_HIGH = 2'b01,
    D_LOW  = 2'b11
  } d_class_e;

  typedef struct packed {
    logic [F_W-1:0] f;
    logic [T_W-1:0] t;
    logic [P_W-1:0] p;
    d_class_e       d;
    logic           under;
    logic           over;
  } wdc_result_t;
endpackage

// File: rtl/wdc_midpoint.sv
module wdc_midpoint
  import wdc_pkg::*;
#(
  parameter int LIN_W   = 15,
  parameter int TB_FAST = 12,
  parameter int TB_SLOW = 11
) (
  input  logic                    fast,
  input  logic [F_W-1:0]          a_f,
  input  logic [T_W-1:0]          a_t,
  input  logic [P_W-1:0]          a_p,
  input  logic [F_W-1:0]          b_f,
  input  logic [T_W-1:0]          b_t,
  input  logic [P_W-1:0]          b_p,
  output logic signed [LIN_W-1:0] lin_avg
);
  logic [LIN_W-1:0] tb;
  logic [LIN_W-1:0] lin_a, lin_b, sum_ab;

  assign tb = fast ? LIN_W'(TB_FAST) : LIN_W'(TB_SLOW);

  // linear position = (fine * bound + coarse) * 8 + phase
  assign lin_a  = (((LIN_W'(a_f) * tb) + LIN_W'(a_t)) << P_W) + LIN_W'(a_p);
  assign lin_b  = (((LIN_W'(b_f) * tb) + LIN_W'(b_t)) << P_W) + LIN_W'(b_p);
  assign sum_ab = lin_a + lin_b;
  assign lin_avg = signed'(sum_ab >> 1);
endmodule

// File: rtl/wdc_normalize.sv
module wdc_normalize
  import wdc_pkg::*;
#(
  parameter int LIN_W    = 15,
  parameter int TB_FAST  = 12,
  parameter int TB_SLOW  = 11,
  parameter int F_LEVELS = 4
) (
  input  logic                    fast,
  input  logic signed [LIN_W-1:0] lin,
  output logic [F_W-1:0]          f,
  output logic [T_W-1:0]          t,
  output logic [P_W-1:0]          p,
  output logic                    under,
  output logic                    over
);
  localparam int SPAN_FAST = TB_FAST << P_W;
  localparam int SPAN_SLOW = TB_SLOW << P_W;

  logic [F_LEVELS-1:0]      ge;
  logic signed [LIN_W-1:0]  tb_s, coarse, fx, t_raw;
  logic [F_W-1:0]           f_raw;
  logic [LIN_W-1:T_W]       unused_t_hi;

  assign tb_s = fast ? LIN_W'(TB_FAST) : LIN_W'(TB_SLOW);

  // thermometer of fine-level boundaries; the top one is the overflow limit
  for (genvar k = 0; k < F_LEVELS; k++) begin : g_lvl
    logic signed [LIN_W-1:0] lim;
    assign lim   = fast ? LIN_W'(SPAN_FAST * (k + 1)) : LIN_W'(SPAN_SLOW * (k + 1));
    assign ge[k] = (lin >= lim);
  end

  assign under  = lin[LIN_W-1];
  assign over   = ge[F_LEVELS-1];
  assign f_raw  = F_W'($countones(ge[F_LEVELS-2:0]));
  assign coarse = lin >>> P_W;
  assign fx     = LIN_W'(f_raw);
  assign t_raw  = coarse - (fx * tb_s);
  assign unused_t_hi = t_raw[LIN_W-1:T_W];

  always_comb begin
    if (under) begin
      f = '0;
      t = '0;
      p = '0;
    end else if (over) begin
      f = F_W'(F_LEVELS - 1);
      t = T_W'(tb_s - 1);
      p = '1;
    end else begin
      f = f_raw;
      t = t_raw[T_W-1:0];
      p = lin[P_W-1:0];
    end
  end
endmodule

// File: rtl/wdc_field_map.sv
module wdc_field_map
  import wdc_pkg::*;
#(
  parameter int LOW_SLOW   = 1,
  parameter int HIGH_SLOW  = 6,
  parameter int LOW_FAST   = 2,
  parameter int HIGH_FAST  = 9,
  parameter int FORCE_T    = 9,
  parameter int FORCE_P    = 4
) (
  input  logic           fast,
  input  logic [T_W-1:0] t,
  input  logic [P_W-1:0] p_in,
  output logic [P_W-1:0] p_out,
  output d_class_e       d
);
  logic [T_W-1:0] lo_th, hi_th;
  logic           force_hit;

  assign lo_th = fast ? T_W'(LOW_FAST)  : T_W'(LOW_SLOW);
  assign hi_th = fast ? T_W'(HIGH_FAST) : T_W'(HIGH_SLOW);

  // around the coarse step FORCE_T -> FORCE_T+1 the phase is pinned to mid
  assign force_hit = fast &&
                     (((t == T_W'(FORCE_T))     && (p_in >= P_W'(FORCE_P))) ||
                      ((t == T_W'(FORCE_T + 1)) && (p_in <  P_W'(FORCE_P))));
  assign p_out = force_hit ? P_W'(FORCE_P) : p_in;

  always_comb begin
    if (t <= lo_th)     d = D_LOW;
    else if (t > hi_th) d = D_HIGH;
    else                d = D_MID;
  end
endmodule

// File: rtl/wdc_encoder.sv
module wdc_encoder
  import wdc_pkg::*;
#(
  parameter int IN_W      = 6,
  parameter int TB_FAST   = 12,
  parameter int TB_SLOW   = 11,
  parameter int F_LEVELS  = 4,
  parameter int LOW_SLOW  = 1,
  parameter int HIGH_SLOW = 6,
  parameter int LOW_FAST  = 2,
  parameter int HIGH_FAST = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_mid,
  input  logic                   fast_mode,
  input  logic signed [IN_W-1:0] dly_f,
  input  logic signed [IN_W-1:0] dly_t,
  input  logic signed [IN_W-1:0] dly_p,
  input  logic [1:0]             lo_f,
  input  logic [3:0]             lo_t,
  input  logic [2:0]             lo_p,
  input  logic [1:0]             hi_f,
  input  logic [3:0]             hi_t,
  input  logic [2:0]             hi_p,
  output logic                   res_valid,
  output logic [1:0]             res_f,
  output logic [3:0]             res_t,
  output logic [2:0]             res_p,
  output logic [1:0]             res_d,
  output logic                   res_under,
  output logic                   res_over
);
  localparam int LIN_W = IN_W + $clog2(TB_FAST) + P_W + 2;

  logic signed [LIN_W-1:0] fx, tx, px, tb_s, lin_enc, lin_mid, lin_sel;
  logic [F_W-1:0]          n_f;
  logic [T_W-1:0]          n_t;
  logic [P_W-1:0]          n_p, m_p;
  logic                    n_under, n_over;
  d_class_e                m_d;
  wdc_result_t             res_q;
  logic                    valid_q, fast_q;

  // linearise the signed request; size casts sign-extend
  assign fx      = LIN_W'(dly_f);
  assign tx      = LIN_W'(dly_t);
  assign px      = LIN_W'(dly_p);
  assign tb_s    = fast_mode ? LIN_W'(TB_FAST) : LIN_W'(TB_SLOW);
  assign lin_enc = (((fx * tb_s) + tx) <<< P_W) + px;

  wdc_midpoint #(.LIN_W(LIN_W), .TB_FAST(TB_FAST), .TB_SLOW(TB_SLOW)) u_mid (
    .fast(fast_mode),
    .a_f(lo_f), .a_t(lo_t), .a_p(lo_p),
    .b_f(hi_f), .b_t(hi_t), .b_p(hi_p),
    .lin_avg(lin_mid)
  );

  assign lin_sel = req_mid ? lin_mid : lin_enc;

  wdc_normalize #(.LIN_W(LIN_W), .TB_FAST(TB_FAST), .TB_SLOW(TB_SLOW),
                  .F_LEVELS(F_LEVELS)) u_norm (
    .fast(fast_mode), .lin(lin_sel),
    .f(n_f), .t(n_t), .p(n_p), .under(n_under), .over(n_over)
  );

  wdc_field_map #(.LOW_SLOW(LOW_SLOW), .HIGH_SLOW(HIGH_SLOW),
                  .LOW_FAST(LOW_FAST), .HIGH_FAST(HIGH_FAST)) u_map (
    .fast(fast_mode), .t(n_t), .p_in(n_p), .p_out(m_p), .d(m_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      fast_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        fast_q      <= fast_mode;
        res_q.f     <= n_f;
        res_q.t     <= n_t;
        res_q.p     <= m_p;
        res_q.d     <= m_d;
        res_q.under <= n_under;
        res_q.over  <= n_over;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_f     = res_q.f;
  assign res_t     = res_q.t;
  assign res_p     = res_q.p;
  assign res_d     = res_q.d;
  assign res_under = res_q.under;
  assign res_over  = res_q.over;

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_under && res_over));
  // R3
  under_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_under) |-> (res_f == 2'd0 && res_t == 4'd0 && res_p == 3'd0));
  // R4
  over_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_over) |-> (res_f == 2'(F_LEVELS - 1) && res_p == 3'd7));
  // R2
  t_range_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_t < (fast_q ? 4'(TB_FAST) : 4'(TB_SLOW))));
  // R8
  d_code_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_d != 2'b10));
  // R6
  p_force_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && fast_q && res_t == 4'd9) |-> (res_p <= 3'd4));
  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R10
  idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
endmodule

// File: tb/wdc_encoder_bench.sv
module wdc_encoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_mid = 1'b0, fast_mode = 1'b0;
  logic signed [5:0] dly_f = '0, dly_t = '0, dly_p = '0;
  logic [1:0] lo_f = '0, hi_f = '0;
  logic [3:0] lo_t = '0, hi_t = '0;
  logic [2:0] lo_p = '0, hi_p = '0;
  logic res_valid, res_under, res_over;
  logic [1:0] res_f, res_d;
  logic [3:0] res_t;
  logic [2:0] res_p;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [12:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  wdc_encoder u_wdc_encoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mid(req_mid),
    .fast_mode(fast_mode), .dly_f(dly_f), .dly_t(dly_t), .dly_p(dly_p),
    .lo_f(lo_f), .lo_t(lo_t), .lo_p(lo_p), .hi_f(hi_f), .hi_t(hi_t), .hi_p(hi_p),
    .res_valid(res_valid), .res_f(res_f), .res_t(res_t), .res_p(res_p),
    .res_d(res_d), .res_under(res_under), .res_over(res_over)
  );

  function automatic logic [12:0] fields(int f, int t, int p, bit fast, bit un, bit ov);
    int po, lo, hi, d;
    po = (fast && ((t == 9 && p >= 4) || (t == 10 && p < 4))) ? 4 : p;
    lo = fast ? 2 : 1;
    hi = fast ? 9 : 6;
    d  = (t <= lo) ? 3 : ((t > hi) ? 1 : 0);
    return {2'(f), 4'(t), 3'(po), 2'(d), un, ov};
  endfunction

  function automatic logic [12:0] model_enc(int f, int t, int p, bit fast);
    int tb;
    tb = fast ? 12 : 11;
    while (p >= 8) begin t++; p -= 8; end
    while (p < 0)  begin t--; p += 8; end
    while (t >= tb) begin f++; t -= tb; end
    while (t < 0)   begin f--; t += tb; end
    if (f < 0)  return fields(0, 0, 0, fast, 1'b1, 1'b0);
    if (f >= 4) return fields(3, tb - 1, 7, fast, 1'b0, 1'b1);
    return fields(f, t, p, fast, 1'b0, 1'b0);
  endfunction

  function automatic logic [12:0] model_mid(int af, int at, int ap, int bf, int bt, int bp, bit fast);
    int tb, va, vb, v;
    tb = fast ? 12 : 11;
    va = (af * tb + at) * 8 + ap;
    vb = (bf * tb + bt) * 8 + bp;
    v  = (va + vb) >> 1;
    return fields(v / (tb * 8), (v >> 3) % tb, v & 7, fast, 1'b0, 1'b0);
  endfunction

  task automatic send_enc(int f, int t, int p, bit fast, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mid = 1'b0; fast_mode = fast;
    dly_f = 6'(f); dly_t = 6'(t); dly_p = 6'(p);
    exp_q.push_back(model_enc(f, t, p, fast));
    tag_q.push_back(tag);
  endtask

  task automatic send_mid(int af, int at, int ap, int bf, int bt, int bp, bit fast, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mid = 1'b1; fast_mode = fast;
    lo_f = 2'(af); lo_t = 4'(at); lo_p = 3'(ap);
    hi_f = 2'(bf); hi_t = 4'(bt); hi_p = 3'(bp);
    exp_q.push_back(model_mid(af, at, ap, bf, bt, bp, fast));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compares each result against the queued expectation
  always @(posedge clk) begin
    #1;
    if (!rst && res_valid) begin
      logic [12:0] got, exp;
      string tg;
      got = {res_f, res_t, res_p, res_d, res_under, res_over};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10: unexpected result got=%h expected=none", got);
      end else begin
        exp = exp_q.pop_front();
        tg  = tag_q.pop_front();
        if (got !== exp) begin
          bad++;
          $display("FAIL %s: got f=%0d t=%0d p=%0d d=%b u=%b o=%b expected f=%0d t=%0d p=%0d d=%b u=%b o=%b",
                   tg, got[12:11], got[10:7], got[6:4], got[3:2], got[1], got[0],
                   exp[12:11], exp[10:7], exp[6:4], exp[3:2], exp[1], exp[0]);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (res_valid !== 1'b0 || {res_f, res_t, res_p, res_d, res_under, res_over} !== 13'd0) begin
      bad++;
      $display("FAIL R10: reset got valid=%b fields=%h expected 0/0", res_valid,
               {res_f, res_t, res_p, res_d, res_under, res_over});
    end

    send_enc(0, 0, 0, 0, "R8");
    send_enc(0, 0, 8, 0, "R1");
    send_enc(1, 0, -1, 0, "R1");
    send_enc(0, 11, 0, 0, "R2");
    send_enc(0, 11, 0, 1, "R2");
    send_enc(0, 12, 0, 1, "R2");
    send_enc(2, -1, 3, 1, "R2");
    send_enc(-1, 5, 5, 0, "R3");
    send_enc(0, 0, -1, 1, "R3");
    send_enc(4, 0, 0, 0, "R4");
    send_enc(3, 11, 7, 1, "R4");
    send_enc(3, 10, 8, 0, "R4");
    send_enc(3, 10, 7, 0, "R5");
    send_enc(0, 9, 5, 1, "R6");
    send_enc(0, 10, 2, 1, "R6");
    send_enc(0, 9, 3, 1, "R6");
    send_enc(0, 10, 4, 1, "R6");
    send_enc(0, 9, 5, 0, "R7");
    send_enc(0, 10, 2, 0, "R7");
    send_enc(1, 2, 0, 1, "R8");
    send_enc(1, 3, 0, 1, "R8");
    send_enc(1, 10, 0, 1, "R8");
    send_enc(1, 1, 0, 0, "R8");
    send_enc(1, 2, 0, 0, "R8");
    send_enc(1, 6, 0, 0, "R8");
    send_enc(1, 7, 0, 0, "R8");
    send_mid(0, 3, 2, 1, 2, 5, 0, "R9");
    send_mid(0, 3, 2, 1, 2, 5, 1, "R9");
    send_mid(3, 10, 7, 3, 10, 7, 0, "R9");
    send_mid(0, 0, 0, 0, 0, 1, 1, "R9");
    idle(5);

    for (int i = 0; i < 400; i++) begin
      bit fm;
      fm = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0)
        send_mid($urandom_range(0, 3), $urandom_range(0, fm ? 11 : 10), $urandom_range(0, 7),
                 $urandom_range(0, 3), $urandom_range(0, fm ? 11 : 10), $urandom_range(0, 7),
                 fm, "R9");
      else
        send_enc($urandom_range(0, 7) - 2, $urandom_range(0, 40) - 15,
                 $urandom_range(0, 27) - 10, fm, "R1");
      if ($urandom_range(0, 7) == 0) idle(2);
    end
    idle(6);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10: pending results got=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule